// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block turns a short byte stream into a complete low-speed USB packet on the D+ and D- pads. When a request arrives it takes the bus. It drives the idle J state with the pad drivers enabled for one bit time. It then sends the sync byte, followed by the packet bytes, least significant bit first. The bytes are NRZI-coded and bit-stuffed. The packet closes with an end-of-packet sequence, after which the drivers are released. Every bit on the line lasts a fixed number of clock cycles, so the clock has to be an exact multiple of the low-speed bit rate.

Two kinds of request exist. A data request takes a total byte count that includes the sync byte, and pulls the remaining bytes from an external source one at a time. Each byte is fetched in the last cycle before its first bit goes out, so no idle slot appears between bytes. A handshake request needs no source at all: it sends sync followed by an ACK or NAK PID. The block also keeps a pending device address. That address is moved into the active address register when a data packet ends, and never when a handshake ends. The active address is held shifted left by one bit, with a zero in bit 0.

Top module: `ls_pkt_tx`

## Requirements
- R1: While reset is asserted and just after it is released, oe, dp, dm, busy and byte_req are 0 and dev_addr is 0.
- R2: A start or hs_req pulse seen while idle sets busy and oe in the next cycle. The pads then hold J (dp=0, dm=1) for exactly 8 cycles before the first sync bit. When start and hs_req arrive in the same cycle, a data packet is sent.
- R3: The first byte on the line is the sync byte 0x80, sent LSB first. Each bit slot lasts 8 cycles. A data packet carries pkt_len bytes in total, sync included.
- R4: NRZI coding applies to every bit: a 0 bit toggles the line between J and K (K is dp=1, dm=0), and a 1 bit holds the line. Data bytes are sent LSB first, in the order the source provides them.
- R5: After six 1 bits in a row, an extra toggled slot is inserted and the run count restarts. This also applies when the run spans a byte boundary, and when it ends on the last bit before the end of packet.
- R6: For each data byte after sync, byte_req is high for exactly one cycle: the last cycle before that byte's first bit appears. byte_data is taken on that same clock edge. A packet of pkt_len bytes issues pkt_len-1 requests.
- R7: After the last slot, dp and dm are both 0 for 16 cycles, then J is driven for 8 cycles. After that, oe, dp, dm and busy all drop to 0 together.
- R8: A handshake request sends sync followed by 0xD2 when hs_nak=0 (ACK), or 0x5A when hs_nak=1 (NAK). It never raises byte_req.
- R9: A set_addr pulse loads addr_in into the pending register and leaves dev_addr unchanged. When a data packet reaches its end of packet, dev_addr becomes {pending, 1'b0}. A handshake packet leaves dev_addr unchanged.
- R10: A start or hs_req that arrives while busy is high is ignored. The packet in progress is unchanged, and no further packet follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a data packet |
| hs_req | input | 1 | Begin a handshake packet |
| hs_nak | input | 1 | Handshake kind: 0 ACK, 1 NAK |
| pkt_len | input | LEN_W | Data packet byte count including sync (at least 1) |
| byte_data | input | 8 | Next data byte, taken when byte_req is high |
| byte_req | output | 1 | One-cycle request for the next data byte |
| set_addr | input | 1 | Load addr_in into the pending address |
| addr_in | input | ADDR_W | New device address |
| dev_addr | output | ADDR_W+1 | Active address, shifted left by one |
| dp | output | 1 | D+ pad value |
| dm | output | 1 | D- pad value |
| oe | output | 1 | Pad driver enable |
| busy | output | 1 | High from bus acquisition until release |

## Verification
The checker assumes two things about the inputs. First, pkt_len is at least 1 whenever a data request is issued. Second, byte_data already carries the correct byte in the cycle byte_req is high, because the byte is captured on that edge with no holding stage. The bench meets both conditions: every pkt_len in its table is between 1 and 4, and byte_data is driven by a pointer into a small source array that only advances on the clock edge that consumes a request. Stray requests are issued only during a packet, where the block must ignore them.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREP,
        PH_DATA,
        PH_SE0,
        PH_JEND
    } tx_phase_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
    parameter int BIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ls_tx_nrzi_stuff.sv
module ls_tx_nrzi_stuff #(
    parameter int STUFF_RUN = 6,
    localparam int RW = $clog2(STUFF_RUN + 1)
) (
    input  logic          line_k,
    input  logic [RW-1:0] run_cnt,
    input  logic          data_bit,
    input  logic          stuff_slot,
    output logic          line_k_next,
    output logic [RW-1:0] run_next,
    output logic          stuff_next
);
    logic [RW-1:0] run_inc;

    always_comb begin
        run_inc = run_cnt + 1'b1;
        if (stuff_slot) begin
            line_k_next = ~line_k;
            run_next    = '0;
            stuff_next  = 1'b0;
        end else if (data_bit) begin
            line_k_next = line_k;
            run_next    = run_inc;
            stuff_next  = (run_inc == RW'(STUFF_RUN));
        end else begin
            line_k_next = ~line_k;
            run_next    = '0;
            stuff_next  = 1'b0;
        end
    end

endmodule

// File: rtl/ls_tx_addr_reg.sv
module ls_tx_addr_reg #(
    parameter int ADDR_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic          commit,
    output logic [ADDR_W:0] dev_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] pend;
        logic [ADDR_W:0]   act;
    } addr_reg_t;

    addr_reg_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (commit) begin
            a_d.act = {a_q.pend, 1'b0};
        end
        if (load) begin
            a_d.pend = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign dev_addr = a_q.act;

endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
    import ls_tx_pkg::*;
#(
    parameter int BIT_CYCLES = 8,
    parameter int STUFF_RUN  = 6,
    parameter int LEN_W      = 8,
    parameter int ADDR_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hs_req,
    input  logic              hs_nak,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [7:0]        byte_data,
    output logic              byte_req,
    input  logic              set_addr,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W:0]   dev_addr,
    output logic              dp,
    output logic              dm,
    output logic              oe,
    output logic              busy
);
    localparam int RW = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        tx_phase_e        phase;
        logic             line_k;
        logic [7:0]       sh;
        logic [3:0]       bits_left;
        logic [LEN_W-1:0] bytes_left;
        logic [RW-1:0]    run;
        logic             stuff_pend;
        logic             first;
        logic             hs;
        logic [7:0]       pid;
        logic             seg;
    } tx_reg_t;

    tx_reg_t cur_q, nxt_d;

    logic          tick;
    logic          timer_run;
    logic          commit;
    logic          req_c;

    // slot selection
    logic [7:0]    src_byte;
    logic          use_stuff;
    logic          from_sh;
    logic          from_new;
    logic          pkt_done;
    logic          enc_bit;
    logic          enc_line;
    logic [RW-1:0] enc_run;
    logic          enc_stuff;

    assign timer_run = (cur_q.phase != PH_IDLE);

    ls_tx_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    always_comb begin
        if (cur_q.first) begin
            src_byte = SYNC_BYTE;
        end else if (cur_q.hs) begin
            src_byte = cur_q.pid;
        end else begin
            src_byte = byte_data;
        end
        use_stuff = cur_q.stuff_pend;
        from_sh   = !use_stuff && (cur_q.bits_left != 4'd0);
        from_new  = !use_stuff && (cur_q.bits_left == 4'd0)
                    && (cur_q.first || (cur_q.bytes_left != '0));
        pkt_done  = !use_stuff && (cur_q.bits_left == 4'd0)
                    && !cur_q.first && (cur_q.bytes_left == '0);
        enc_bit   = from_sh ? cur_q.sh[0] : src_byte[0];
    end

    ls_tx_nrzi_stuff #(.STUFF_RUN(STUFF_RUN)) u_enc (
        .line_k      (cur_q.line_k),
        .run_cnt     (cur_q.run),
        .data_bit    (enc_bit),
        .stuff_slot  (use_stuff),
        .line_k_next (enc_line),
        .run_next    (enc_run),
        .stuff_next  (enc_stuff)
    );

    always_comb begin
        nxt_d  = cur_q;
        commit = 1'b0;
        req_c  = 1'b0;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (start || hs_req) begin
                    nxt_d.phase      = PH_PREP;
                    nxt_d.line_k     = 1'b0;
                    nxt_d.sh         = '0;
                    nxt_d.bits_left  = 4'd0;
                    nxt_d.run        = '0;
                    nxt_d.stuff_pend = 1'b0;
                    nxt_d.first      = 1'b1;
                    nxt_d.seg        = 1'b0;
                    if (start) begin
                        nxt_d.hs         = 1'b0;
                        nxt_d.bytes_left = pkt_len - 1'b1;
                    end else begin
                        nxt_d.hs         = 1'b1;
                        nxt_d.pid        = hs_nak ? PID_NAK : PID_ACK;
                        nxt_d.bytes_left = LEN_W'(1);
                    end
                end
            end
            PH_PREP, PH_DATA: begin
                if (tick) begin
                    if (pkt_done) begin
                        nxt_d.phase = PH_SE0;
                        nxt_d.seg   = 1'b0;
                        commit      = !cur_q.hs;
                    end else begin
                        nxt_d.phase      = PH_DATA;
                        nxt_d.line_k     = enc_line;
                        nxt_d.run        = enc_run;
                        nxt_d.stuff_pend = enc_stuff;
                        if (from_sh) begin
                            nxt_d.sh        = cur_q.sh >> 1;
                            nxt_d.bits_left = cur_q.bits_left - 4'd1;
                        end
                        if (from_new) begin
                            nxt_d.sh        = src_byte >> 1;
                            nxt_d.bits_left = 4'd7;
                            if (cur_q.first) begin
                                nxt_d.first = 1'b0;
                            end else begin
                                nxt_d.bytes_left = cur_q.bytes_left - 1'b1;
                                req_c            = !cur_q.hs;
                            end
                        end
                    end
                end
            end
            PH_SE0: begin
                if (tick) begin
                    if (cur_q.seg) begin
                        nxt_d.phase = PH_JEND;
                    end else begin
                        nxt_d.seg = 1'b1;
                    end
                end
            end
            PH_JEND: begin
                if (tick) begin
                    nxt_d.phase = PH_IDLE;
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    ls_tx_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (set_addr),
        .addr_in  (addr_in),
        .commit   (commit),
        .dev_addr (dev_addr)
    );

    always_comb begin
        unique case (cur_q.phase)
            PH_PREP, PH_JEND: begin dp = 1'b0;         dm = 1'b1;          oe = 1'b1; end
            PH_DATA:          begin dp = cur_q.line_k; dm = ~cur_q.line_k; oe = 1'b1; end
            PH_SE0:           begin dp = 1'b0;         dm = 1'b0;          oe = 1'b1; end
            default:          begin dp = 1'b0;         dm = 1'b0;          oe = 1'b0; end
        endcase
    end

    assign busy     = (cur_q.phase != PH_IDLE);
    assign byte_req = req_c;

endmodule

// File: rtl/ls_pkt_tx_chk.sv
module ls_pkt_tx_chk #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            hs_req,
    input logic            byte_req,
    input logic [ADDR_W:0] dev_addr,
    input logic            dp,
    input logic            dm,
    input logic            oe,
    input logic            busy
);

    a_r2_request_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((start || hs_req) && !busy) |=> (busy && oe && !dp && dm));

    a_r3_no_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp && dm));

    a_r6_req_only_driving: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> (busy && oe));

    a_r7_j_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(oe && dm && !dp));

    a_r7_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!oe && !dp && !dm));

    a_r9_addr_moves_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> busy);

endmodule

bind ls_pkt_tx ls_pkt_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hs_req   (hs_req),
    .byte_req (byte_req),
    .dev_addr (dev_addr),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe),
    .busy     (busy)
);

// File: tb/tb_ls_pkt_tx.sv
module tb_ls_pkt_tx;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start, hs_req, hs_nak, set_addr;
    logic [7:0] pkt_len;
    logic [7:0] byte_data;
    logic [6:0] addr_in;
    logic       byte_req, dp, dm, oe, busy;
    logic [7:0] dev_addr;

    always #5 clk = ~clk;

    ls_pkt_tx dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_req(hs_req), .hs_nak(hs_nak),
        .pkt_len(pkt_len), .byte_data(byte_data), .byte_req(byte_req),
        .set_addr(set_addr), .addr_in(addr_in), .dev_addr(dev_addr),
        .dp(dp), .dm(dm), .oe(oe), .busy(busy)
    );

    int errors = 0;
    int checks = 0;

    logic [7:0] src [0:3];
    int req_cnt = 0;
    int base = 0;
    always @(posedge clk) if (byte_req) req_cnt <= req_cnt + 1;
    assign byte_data = src[2'(req_cnt - base)];

    logic cap_dp [0:1023];
    logic cap_dm [0:1023];
    logic cap_oe [0:1023];
    logic cap_busy [0:1023];
    logic cap_req [0:1023];
    logic slot_k [0:255];
    int   nslots;
    int   exp_req [0:7];
    int   nreq;
    int   i_end;

    // fields: [31] handshake, [30] nak, [26:24] length, [23:0] data bytes
    localparam logic [31:0] VEC [0:8] = '{
        32'h0401_0203, 32'h02FF_0000, 32'h04FF_FFFF,
        32'h8000_0000, 32'hC000_0000, 32'h0100_0000,
        32'h03FC_0000, 32'h02FC_0000, 32'h037E_8100
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic build(input bit hs, input bit nak, input int len,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] all [0:3];
        int n;
        int run;
        logic lvl;
        all[0] = 8'h80; all[1] = b0; all[2] = b1; all[3] = b2;
        if (hs) begin
            all[1] = nak ? 8'h5A : 8'hD2;
            n = 2;
        end else begin
            n = len;
        end
        nslots = 0; nreq = 0; run = 0; lvl = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k >= 1 && !hs) begin
                exp_req[nreq] = 8 + 8 * nslots - 1;
                nreq++;
            end
            for (int j = 0; j < 8; j++) begin
                if (!all[k][j]) lvl = ~lvl;
                slot_k[nslots] = lvl; nslots++;
                run = all[k][j] ? run + 1 : 0;
                if (run == 6) begin
                    lvl = ~lvl;
                    slot_k[nslots] = lvl; nslots++;
                    run = 0;
                end
            end
        end
    endtask

    task automatic send(input bit hs, input bit nak, input int len,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input bit both, input bit inject);
        int i;
        int bad;
        int total;
        int got;
        string rtag;
        src[0] = b0; src[1] = b1; src[2] = b2; src[3] = 8'h00;
        build(hs, nak, len, b0, b1, b2);
        @(negedge clk);
        base = req_cnt;
        pkt_len = 8'(len); hs_nak = nak;
        if (hs) hs_req = 1'b1; else start = 1'b1;
        if (both) hs_req = 1'b1;
        @(negedge clk);
        start = 1'b0; hs_req = 1'b0;
        i = 0;
        while (i < 1000) begin
            cap_dp[i] = dp; cap_dm[i] = dm; cap_oe[i] = oe;
            cap_busy[i] = busy; cap_req[i] = byte_req;
            if (inject && i == 40) begin start = 1'b1; hs_req = 1'b1; end
            if (inject && i == 41) begin start = 1'b0; hs_req = 1'b0; end
            if (!oe) break;
            i++;
            @(negedge clk);
        end
        i_end = i;
        total = 8 + 8 * nslots + 24;
        // R2: idle J for one bit after acquisition
        bad = 0;
        for (int c = 0; c < 8; c++)
            if (!(cap_oe[c] && cap_busy[c] && !cap_dp[c] && cap_dm[c])) bad++;
        chk(bad == 0, "R2", "J lead-in bad samples", bad, 0);
        // R3: sync slots; R4/R5: remaining slots
        bad = 0;
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 8; c++) begin
                int x;
                x = 8 + 8 * s + c;
                if (!(cap_oe[x] && cap_dp[x] == slot_k[s] && cap_dm[x] == !slot_k[s])) bad++;
            end
        chk(bad == 0, "R3", "sync waveform bad samples", bad, 0);
        bad = 0;
        for (int s = 8; s < nslots; s++)
            for (int c = 0; c < 8; c++) begin
                int x;
                x = 8 + 8 * s + c;
                if (!(cap_oe[x] && cap_dp[x] == slot_k[s] && cap_dm[x] == !slot_k[s])) bad++;
            end
        chk(bad == 0, "R4 R5", "payload waveform bad samples", bad, 0);
        // R7: end of packet
        bad = 0;
        for (int c = 0; c < 24; c++) begin
            int x;
            x = 8 + 8 * nslots + c;
            if (c < 16) begin
                if (!(cap_oe[x] && !cap_dp[x] && !cap_dm[x])) bad++;
            end else begin
                if (!(cap_oe[x] && !cap_dp[x] && cap_dm[x])) bad++;
            end
        end
        chk(bad == 0, "R7", "EOP bad samples", bad, 0);
        chk(i_end == total && !cap_busy[i_end] && !cap_dp[i_end] && !cap_dm[i_end],
            "R7", "release cycle", i_end, total);
        // R6 / R8: byte request timing
        rtag = hs ? "R8" : "R6";
        got = 0; bad = 0;
        for (int x = 0; x <= i_end; x++)
            if (cap_req[x]) begin
                if (got >= nreq || exp_req[got] != x) bad++;
                got++;
            end
        chk(got == nreq && bad == 0, rtag, "byte request count", got, nreq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0] pend;
        logic [7:0] exp_addr;
        rst_n = 1'b0; start = 1'b0; hs_req = 1'b0; hs_nak = 1'b0; set_addr = 1'b0;
        pkt_len = 8'd0; addr_in = 7'd0;
        src[0] = 0; src[1] = 0; src[2] = 0; src[3] = 0;
        repeat (3) @(negedge clk);
        chk(!oe, "R1", "oe in reset", int'(oe), 0);
        chk(!dp && !dm, "R1", "pads in reset", int'({dp, dm}), 0);
        chk(!busy, "R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_addr == 8'h00, "R1", "dev_addr after reset", int'(dev_addr), 0);
        chk(!byte_req && !oe && !busy, "R1", "idle after reset",
            int'({byte_req, oe, busy}), 0);

        pend = 7'h2A;
        set_addr = 1'b1; addr_in = pend;
        @(negedge clk);
        set_addr = 1'b0;
        @(negedge clk);
        chk(dev_addr == 8'h00, "R9", "pending load leaves active", int'(dev_addr), 0);
        exp_addr = 8'h00;

        for (int v = 0; v < 9; v++) begin
            logic [31:0] e;
            e = VEC[v];
            if (v == 3) begin
                pend = 7'h15;
                @(negedge clk);
                set_addr = 1'b1; addr_in = pend;
                @(negedge clk);
                set_addr = 1'b0;
            end
            send(e[31], e[30], int'(e[26:24]), e[23:16], e[15:8], e[7:0], 1'b0, 1'b0);
            if (!e[31]) exp_addr = {pend, 1'b0};
            repeat (3) @(negedge clk);
            chk(dev_addr == exp_addr, "R9", "active address after packet",
                int'(dev_addr), int'(exp_addr));
        end

        // R2: simultaneous requests give a data packet
        send(1'b0, 1'b0, 2, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0);

        // R10: requests during a packet are ignored
        send(1'b0, 1'b0, 3, 8'h55, 8'hAA, 8'h00, 1'b0, 1'b1);
        repeat (60) @(negedge clk);
        chk(!oe && !busy, "R10", "no packet after ignored request",
            int'({oe, busy}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule